// File: doc/BRIEF.md
# Multiplexed Signed Voltmeter Display Driver

This block drives a six-position, time-multiplexed seven-segment display that shows a single converter reading. It takes an overrange flag, a polarity flag and a packed BCD magnitude in millivolts. It produces a one-hot digit select, an active-high segment pattern and a separate decimal-point bit. A board-level wrapper can then invert and bundle these for the panel.

Each position has a fixed meaning. The leftmost position flags overrange, and the next one carries the polarity. The last four positions show the magnitude as volts with three decimals, so 1234 mV reads as 1.234. A parameterised divider sets how long each position stays selected. At the default of 50000 clock cycles this is 1 ms at 50 MHz. The segment outputs follow the data inputs combinationally for the position that is currently selected.

Top module: `vmeter_display`

## Requirements
- R1: While reset is low, and until the first scan step, `digitSel` is 6'b000001 and `segOut` and `dotOut` are all zero, whatever the data inputs are. The first scan step occurs on the STEP_CYCLES-th rising clock edge after reset is released. After that step, position 0 is shown live.
- R2: After the first step, the selected position advances by one every STEP_CYCLES cycles and wraps from position 5 back to position 0. Position p is selected by `digitSel[p]` alone. Bit 0 is the leftmost position and bit 5 is the rightmost.
- R3: Position 0 shows all seven segments (7'h7F) when `overRange` is 1 and is blank when it is 0.
- R4: Position 1 shows segment g only (7'h40) when `signNeg` is 1, meaning a negative input, and is blank when it is 0.
- R5: Positions 2, 3, 4 and 5 show the BCD nibbles `magBcd[15:12]`, `[11:8]`, `[7:4]` and `[3:0]` respectively. `magBcd[19:16]` has no effect on any output.
- R6: A digit value is drawn with `segOut` bit 0 as segment a through bit 6 as segment g, active high. The codes are 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F (hex).
- R7: A magnitude nibble of 10 to 15 blanks its position (segOut = 0).
- R8: `dotOut` is 1 exactly when position 2 is selected after the first step. It is 0 on every other position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| overRange | input | 1 | Converter out-of-range flag |
| signNeg | input | 1 | 1 when the reading is negative |
| magBcd | input | 20 | Packed BCD magnitude in millivolts, least significant nibble in bits 3:0 |
| digitSel | output | 6 | One-hot position select, bit 0 leftmost |
| segOut | output | 7 | Segment pattern, bit 0 = a ... bit 6 = g, active high |
| dotOut | output | 1 | Decimal point for the selected position |

## Verification
The bench uses a short step period and walks the scan through two full rotations. At each position it sweeps every nibble value and every flag combination, while the other nibbles hold distracting digits. This catches a driver that reverses the nibble order or reads the wrong nibble: it would show a neighbour's digit. It also catches a driver that lets the unused top nibble through, which would corrupt the thousands digit.

The blank window after reset is checked with both flags set. A design that shows live data before the first step would light the overrange position at once. The bench also checks wrap timing and repeats it after a reset issued mid-scan. A counter that fails to restart, or that jumps past position 5, would select the wrong bit at a predictable edge. Codes 10 to 15 are checked for blanking, and the point is checked on every position. This catches a decoder that draws garbage glyphs and a point placed on the wrong digit.

// File: rtl/vm_pkg.sv
package vm_pkg;
  localparam int unsigned NUM_POS    = 6;
  localparam int unsigned POS_W      = 3;
  localparam int unsigned MAG_DIGITS = 4;
  localparam int unsigned MAG_FIRST  = NUM_POS - MAG_DIGITS;
  localparam int unsigned BCD_W      = 20;
  localparam logic [6:0]  SEG_ALL    = 7'h7F;
  localparam logic [6:0]  SEG_MINUS  = 7'h40;

  typedef struct packed {
    logic             live;
    logic             stepStb;
    logic [POS_W-1:0] pos;
  } scanCtl_t;

  function automatic logic [6:0] bcdToSeg(input logic [3:0] digit);
    logic [6:0] pat;
    case (digit)
      4'd0: pat = 7'h3F;
      4'd1: pat = 7'h06;
      4'd2: pat = 7'h5B;
      4'd3: pat = 7'h4F;
      4'd4: pat = 7'h66;
      4'd5: pat = 7'h6D;
      4'd6: pat = 7'h7D;
      4'd7: pat = 7'h07;
      4'd8: pat = 7'h7F;
      4'd9: pat = 7'h6F;
      default: pat = 7'h00;
    endcase
    return pat;
  endfunction
endpackage

// File: rtl/vm_scan_ctrl.sv
module vm_scan_ctrl
  import vm_pkg::*;
#(
  parameter int unsigned STEP_CYCLES = 50000
) (
  input  logic     clk,
  input  logic     rstN,
  output scanCtl_t ctl
);
  localparam int unsigned CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STEP_CYCLES - 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_POS - 1);

  logic [CNT_W-1:0] divCnt;
  logic             stepNow;
  logic             live;
  logic [POS_W-1:0] pos;

  assign stepNow = (divCnt == LAST_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      live   <= 1'b0;
      pos    <= '0;
    end else begin
      divCnt <= stepNow ? '0 : divCnt + 1'b1;
      if (stepNow) begin
        live <= 1'b1;
        if (live) begin
          pos <= (pos == LAST_POS) ? '0 : pos + 1'b1;
        end
      end
    end
  end

  assign ctl.live    = live;
  assign ctl.stepStb = stepNow;
  assign ctl.pos     = pos;
endmodule

// File: rtl/vm_digit_path.sv
module vm_digit_path
  import vm_pkg::*;
(
  input  scanCtl_t           ctl,
  input  logic               overRange,
  input  logic               signNeg,
  input  logic [BCD_W-1:0]   magBcd,
  output logic [NUM_POS-1:0] digitSel,
  output logic [6:0]         segOut,
  output logic               dotOut
);
  logic [3:0] magNib [MAG_DIGITS];
  logic [3:0] curNib;

  for (genvar g = 0; g < NUM_POS; g++) begin : g_sel
    assign digitSel[g] = (ctl.pos == POS_W'(g));
  end

  for (genvar g = 0; g < MAG_DIGITS; g++) begin : g_nib
    assign magNib[g] = magBcd[(MAG_DIGITS-1-g)*4 +: 4];
  end

  always_comb begin
    curNib = 4'hF;
    for (int i = 0; i < MAG_DIGITS; i++) begin
      if (ctl.pos == POS_W'(MAG_FIRST + i)) curNib = magNib[i];
    end
  end

  always_comb begin
    segOut = '0;
    dotOut = 1'b0;
    if (ctl.live) begin
      if (ctl.pos == POS_W'(0)) begin
        segOut = overRange ? SEG_ALL : 7'h00;
      end else if (ctl.pos == POS_W'(1)) begin
        segOut = signNeg ? SEG_MINUS : 7'h00;
      end else begin
        segOut = bcdToSeg(curNib);
        dotOut = (ctl.pos == POS_W'(MAG_FIRST));
      end
    end
  end
endmodule

// File: rtl/vmeter_display.sv
module vmeter_display
  import vm_pkg::*;
#(
  parameter int unsigned STEP_CYCLES = 50000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        overRange,
  input  logic        signNeg,
  input  logic [19:0] magBcd,
  output logic [5:0]  digitSel,
  output logic [6:0]  segOut,
  output logic        dotOut
);
  scanCtl_t scanCtl;

  vm_scan_ctrl #(.STEP_CYCLES(STEP_CYCLES)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (scanCtl)
  );

  vm_digit_path u_path (
    .ctl       (scanCtl),
    .overRange (overRange),
    .signNeg   (signNeg),
    .magBcd    (magBcd),
    .digitSel  (digitSel),
    .segOut    (segOut),
    .dotOut    (dotOut)
  );
endmodule

// File: rtl/vmeter_display_chk.sv
module vmeter_display_chk (
  input logic       clk,
  input logic       rstN,
  input logic       overRange,
  input logic       signNeg,
  input logic [5:0] digitSel,
  input logic [6:0] segOut,
  input logic       dotOut
);
  // R2
  one_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(digitSel) == 1);

  // R2
  rotate_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (digitSel != $past(digitSel)) |-> (digitSel == {$past(digitSel[4:0]), $past(digitSel[5])}));

  // R8
  dot_place_chk: assert property (@(posedge clk) disable iff (!rstN)
    dotOut |-> digitSel[2]);

  // R3
  overrange_lit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (digitSel[0] && segOut != 7'h00) |-> (overRange && segOut == 7'h7F));

  // R4
  minus_lit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (digitSel[1] && segOut != 7'h00) |-> (signNeg && segOut == 7'h40));
endmodule

bind vmeter_display vmeter_display_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .overRange (overRange),
  .signNeg   (signNeg),
  .digitSel  (digitSel),
  .segOut    (segOut),
  .dotOut    (dotOut)
);

// File: tb/vmeter_display_tb.sv
module vmeter_display_tb;
  localparam int STEP = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        overRange = 1'b0;
  logic        signNeg = 1'b0;
  logic [19:0] magBcd = '0;
  logic [5:0]  digitSel;
  logic [6:0]  segOut;
  logic        dotOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vmeter_display #(.STEP_CYCLES(STEP)) u_dut (
    .clk(clk), .rstN(rstN), .overRange(overRange), .signNeg(signNeg),
    .magBcd(magBcd), .digitSel(digitSel), .segOut(segOut), .dotOut(dotOut)
  );

  function automatic logic [6:0] glyph(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string req, input int pos, input logic [6:0] expSeg, input logic expDot);
    check({req, " sel"}, 14'(digitSel), 14'(6'b1 << pos));
    check({req, " seg"}, 14'(segOut), 14'(expSeg));
    check({req, " dot"}, 14'(dotOut), 14'(expDot));
  endtask

  // Sweeps the inputs for one live position; starts at a negedge after the step edge
  // and returns on the next step edge.
  task automatic sweepPos(input int pos);
    int n = 0;
    if (pos == 0 || pos == 1) begin
      for (int c = 0; c < 4; c++) begin
        overRange = c[0]; signNeg = c[1]; magBcd = 20'h88888;
        #1;
        if (pos == 0) checkAll("R3", 0, c[0] ? 7'h7F : 7'h00, 1'b0);
        else          checkAll("R4", 1, c[1] ? 7'h40 : 7'h00, 1'b0);
        @(negedge clk); n++;
      end
    end else begin
      for (int v = 0; v < 16; v++) begin
        int sh = (5 - pos) * 4;
        logic [19:0] fill = {5{4'((v + 3) % 10)}};
        fill[19:16] = 4'(v);
        fill[sh +: 4] = 4'(v);
        magBcd = fill; overRange = v[0]; signNeg = v[1];
        #1;
        if (v > 9) checkAll("R7", pos, 7'h00, pos == 2);
        else       checkAll("R5 R6 R8", pos, glyph(v), pos == 2);
        @(negedge clk); n++;
      end
    end
    repeat (STEP - n) @(posedge clk);
  endtask

  task automatic blankWindow(input string req);
    overRange = 1'b1; signNeg = 1'b1; magBcd = 20'h12345;
    for (int c = 0; c < STEP - 1; c++) begin
      @(negedge clk);
      checkAll(req, 0, 7'h00, 1'b0);
    end
    @(posedge clk);
  endtask

  initial begin
    overRange = 1'b1; signNeg = 1'b1; magBcd = 20'h19999;
    repeat (3) @(negedge clk);
    checkAll("R1 in reset", 0, 7'h00, 1'b0);
    rstN = 1'b1;
    blankWindow("R1 pre-step");
    for (int k = 0; k < 13; k++) begin
      @(negedge clk);
      sweepPos(k % 6);
    end
    // Mid-scan reset: position 1 is live now
    @(negedge clk);
    repeat (7) @(negedge clk);
    rstN = 1'b0;
    #1;
    checkAll("R1 mid reset", 0, 7'h00, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    blankWindow("R1 after reset");
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      sweepPos(k % 6);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule